// File: doc/BRIEF.md
# Serial Controller Interrupt Vector Generator

This block gathers the interrupt requests of one channel of a serial controller and turns them into an 8-bit vector for the CPU. There are eight sources, each with a 3-bit code: five interval timers, a rising edge on an external sense input, receive data available and transmit buffer empty. Each source has a pending flag that stays latched until it is acknowledged or serviced. A mask register chooses which pending sources take part. A global generation enable gates the interrupt request line.

A strap input picks one of two vector formats. The table-index format builds the vector from bits 7:5 of the device's I/O port address, a channel bit and the source code. The result is always even, so it points at a two-byte table entry. The restart format emits the single-byte restart opcode `11sss111`, where `sss` is the source code. The vector of the winning source appears on the acknowledge bus during an acknowledge cycle. The same vector can also be read at any time from a polled status output, which shows 0xFF when nothing qualifies.

The five timers share one prescaler. The prescaler makes a tick every `TICK_DIV` clocks; the default is 64 clocks, which is one tick per 64 µs at 1 MHz. A timer counts its loaded value down by one on each tick and raises its flag when the count reaches zero.

Top module: `uart_irq_vector_gen`

## Requirements
- R1: After reset, the mask is all zero, generation is off, no flag is pending, `irq` is 0, and both `poll_vec` and `ack_vec` read 0xFF.
- R2: With `strap_restart`=0, the vector is {`port_addr_hi`[2:0], `chan_b`, code[2:0], 1'b0}. Example: receive (code 4) on channel A at address bits 001 gives 0x28.
- R3: With `strap_restart`=1, the vector is {2'b11, code[2:0], 3'b111}. Examples: timer1 gives 0xC7, sense gives 0xD7, receive gives 0xE7, timer5 gives 0xFF.
- R4: The source codes are: timer1=0, timer2=1, sense=2, timer3=3, receive=4, transmit-empty=5, timer4=6, timer5=7. When several sources qualify, the lowest code wins.
- R5: Mask bit i enables the source with code i. A masked source still latches its flag, but it neither raises `irq` nor appears in `poll_vec` until it is unmasked.
- R6: `irq` is 1 only when generation is enabled and at least one pending flag is unmasked. A write with `ctrl_wr`=1 stores `ctrl_gen_en` as the enable.
- R7: While `inta`=1, `ack_vec` carries the winning vector, and the winner's flag clears on that clock edge. While `inta`=0, `ack_vec` is 0xFF.
- R8: A pulse on `rx_avail` sets the receive flag and a pulse on `rx_read` clears it. A pulse on `tx_empty` sets the transmit flag and a pulse on `tx_write` clears it.
- R9: A rising edge of `sense_in` sets the sense flag. Holding the input high does not set it again.
- R10: Loading timer `tmr_sel` (0..4, which are timers 1..5) with N>0 clears that timer's flag. The flag sets after N prescaler ticks of `TICK_DIV` clocks each. Loading 0 stops the timer.
- R11: When a set and a clear of the same flag happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_restart | input | 1 | 1 selects the restart-opcode format, 0 selects the table-index format |
| port_addr_hi | input | 3 | Bits 7:5 of the device's port address |
| chan_b | input | 1 | 0 for channel A, 1 for channel B |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_data | input | 8 | Mask value; bit i enables code i |
| ctrl_wr | input | 1 | Write strobe for the generation enable |
| ctrl_gen_en | input | 1 | Generation enable value |
| tmr_load | input | 1 | Timer load strobe |
| tmr_sel | input | 3 | Timer index 0..4 |
| tmr_value | input | 8 | Timer load value |
| sense_in | input | 1 | External sense level |
| rx_avail | input | 1 | Pulse: received byte available |
| rx_read | input | 1 | Pulse: received byte read |
| tx_empty | input | 1 | Pulse: transmit buffer became empty |
| tx_write | input | 1 | Pulse: transmit buffer written |
| inta | input | 1 | Interrupt acknowledge cycle |
| irq | output | 1 | Interrupt request |
| ack_vec | output | 8 | Vector bus during acknowledge |
| poll_vec | output | 8 | Polled vector status |

## Verification
The bench runs several cases that are easy to get wrong, and each one shows a distinct symptom when the design is wrong:
- **Priority.** Receive and transmit-empty are made pending together. Inverted priority would return 0x2A first instead of 0x28.
- **Sense edge.** The sense input is held high across an acknowledge. A level-triggered design would hand out 0xD7 a second time.
- **Set against clear.** A receive set and a data read land in the same cycle. Letting the clear win would lose the request.
- **Timer5 in restart format.** Its vector is 0xFF, the same value as "nothing pending", so `irq` is what tells them apart.
- **Timers.** Expiry is checked against a window derived from `TICK_DIV`. The bench also checks that loading 0 keeps a timer silent, and that reloading clears a flag that has already fired.
- **Mask.** A source that was masked while it fired must appear once it is unmasked.

// File: rtl/uivg_pkg.sv
// Package: shared constants and source-code mapping for the vector generator.
// Assumes eight sources with 3-bit codes and five interval timers.
package uivg_pkg;
    localparam int NSRC   = 8;
    localparam int CODE_W = 3;
    localparam int NTMR   = 5;
    localparam int VEC_W  = 8;

    localparam logic [CODE_W-1:0] CODE_SENSE = 3'd2;
    localparam logic [CODE_W-1:0] CODE_RX    = 3'd4;
    localparam logic [CODE_W-1:0] CODE_TX    = 3'd5;

    // Source code owned by timer index k (timers 1..5 map to 0,1,3,6,7).
    function automatic logic [CODE_W-1:0] tmr_code(input int k);
        case (k)
            0:       return 3'd0;
            1:       return 3'd1;
            2:       return 3'd3;
            3:       return 3'd6;
            default: return 3'd7;
        endcase
    endfunction
endpackage

// File: rtl/uivg_timer_bank.sv
// Timer bank: one shared prescaler and NTMR down-counters.
// Each counter decrements once per prescaler tick. It pulses its expire output
// for one cycle when the count goes from 1 to 0, and then stops.
// Assumes a load has priority over a tick in the same cycle.
module uivg_timer_bank #(
    parameter int NTMR     = 5,
    parameter int CNT_W    = 8,
    parameter int SEL_W    = 3,
    parameter int TICK_DIV = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    input  logic [CNT_W-1:0] value,
    output logic [NTMR-1:0]  load_hit,
    output logic [NTMR-1:0]  expire
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] PRE_MAX = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_q;
    logic          tick;

    // Prescaler: free-running divider that produces one tick every TICK_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)              pre_q <= '0;
        else if (pre_q == PRE_MAX) pre_q <= '0;
        else                     pre_q <= pre_q + PW'(1);
    end
    assign tick = (pre_q == PRE_MAX);

    for (genvar k = 0; k < NTMR; k++) begin : g_tmr
        logic [CNT_W-1:0] cnt_q;
        logic             run_q;
        logic             exp_q;

        assign load_hit[k] = load && (sel == SEL_W'(k));
        assign expire[k]   = exp_q;

        // Counter k: load or count down, and flag expiry once.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
                run_q <= 1'b0;
                exp_q <= 1'b0;
            end else begin
                exp_q <= 1'b0;
                if (load_hit[k]) begin
                    cnt_q <= value;
                    run_q <= (value != '0);
                end else if (tick && run_q) begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (cnt_q == CNT_W'(1)) begin
                        run_q <= 1'b0;
                        exp_q <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uivg_pend_latch.sv
// Pending latch: one sticky flag per source.
// A set in the same cycle as a clear wins, so no request is lost.
module uivg_pend_latch #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_v,
    input  logic [NSRC-1:0] clr_v,
    output logic [NSRC-1:0] pend_q
);
    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        // Flag i: hold, clear on service, set on event (set dominant).
        always_ff @(posedge clk) begin
            if (!rst_n)        pend_q[i] <= 1'b0;
            else if (set_v[i]) pend_q[i] <= 1'b1;
            else if (clr_v[i]) pend_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/uivg_vec_enc.sv
// Vector encoder: picks the lowest-coded active source and formats its vector.
// The output is 0xFF when no source is active.
// Purely combinational; assumes NSRC == 2**CODE_W.
module uivg_vec_enc #(
    parameter int NSRC   = 8,
    parameter int CODE_W = 3,
    parameter int VEC_W  = 8
) (
    input  logic [NSRC-1:0]   act,
    input  logic              restart,
    input  logic [2:0]        addr_hi,
    input  logic              chb,
    output logic              any,
    output logic [CODE_W-1:0] code,
    output logic [VEC_W-1:0]  vec
);
    // Fixed priority: scan from the top so the lowest set index is kept last.
    always_comb begin
        any  = 1'b0;
        code = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (act[i]) begin
                any  = 1'b1;
                code = CODE_W'(i);
            end
        end
    end

    // Format: restart opcode or table index, 0xFF when idle.
    always_comb begin
        if (!any)         vec = '1;
        else if (restart) vec = {2'b11, code, 3'b111};
        else              vec = {addr_hi, chb, code, 1'b0};
    end
endmodule

// File: rtl/uart_irq_vector_gen.sv
// Top: interrupt vector generator for one serial controller channel.
// Holds the mask and enable registers and the sense edge detector. It routes
// set and clear events into the pending latch, and serves the acknowledge bus
// and the polled vector.
// Assumes the event inputs are single-cycle pulses that are synchronous to clk.
module uart_irq_vector_gen #(
    parameter int TICK_DIV = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_restart,
    input  logic [2:0] port_addr_hi,
    input  logic       chan_b,
    input  logic       mask_wr,
    input  logic [7:0] mask_data,
    input  logic       ctrl_wr,
    input  logic       ctrl_gen_en,
    input  logic       tmr_load,
    input  logic [2:0] tmr_sel,
    input  logic [7:0] tmr_value,
    input  logic       sense_in,
    input  logic       rx_avail,
    input  logic       rx_read,
    input  logic       tx_empty,
    input  logic       tx_write,
    input  logic       inta,
    output logic       irq,
    output logic [7:0] ack_vec,
    output logic [7:0] poll_vec
);
    import uivg_pkg::*;

    logic [NSRC-1:0]   mask_q;
    logic              en_q;
    logic              sense_q;
    logic [NSRC-1:0]   set_v;
    logic [NSRC-1:0]   clr_v;
    logic [NSRC-1:0]   pend_q;
    logic [NTMR-1:0]   tmr_exp;
    logic [NTMR-1:0]   tmr_hit;
    logic              any_act;
    logic [CODE_W-1:0] win_code;

    // Config registers: interrupt mask, generation enable, and the sense history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            en_q    <= 1'b0;
            sense_q <= 1'b0;
        end else begin
            if (mask_wr) mask_q <= mask_data;
            if (ctrl_wr) en_q   <= ctrl_gen_en;
            sense_q <= sense_in;
        end
    end

    uivg_timer_bank #(
        .NTMR(NTMR), .CNT_W(8), .SEL_W(3), .TICK_DIV(TICK_DIV)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .sel(tmr_sel),
        .value(tmr_value), .load_hit(tmr_hit), .expire(tmr_exp)
    );

    // Event routing: collect the set and clear causes for every source code.
    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[CODE_SENSE] = sense_in && !sense_q;
        set_v[CODE_RX]    = rx_avail;
        set_v[CODE_TX]    = tx_empty;
        clr_v[CODE_RX]    = rx_read;
        clr_v[CODE_TX]    = tx_write;
        for (int k = 0; k < NTMR; k++) begin
            set_v[tmr_code(k)] = set_v[tmr_code(k)] | tmr_exp[k];
            clr_v[tmr_code(k)] = clr_v[tmr_code(k)] | tmr_hit[k];
        end
        if (inta && irq) clr_v[win_code] = 1'b1;
    end

    uivg_pend_latch #(.NSRC(NSRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .pend_q(pend_q)
    );

    uivg_vec_enc #(.NSRC(NSRC), .CODE_W(CODE_W), .VEC_W(VEC_W)) u_enc (
        .act(pend_q & mask_q), .restart(strap_restart), .addr_hi(port_addr_hi),
        .chb(chan_b), .any(any_act), .code(win_code), .vec(poll_vec)
    );

    assign irq     = en_q && any_act;
    assign ack_vec = inta ? poll_vec : 8'hFF;
endmodule

// File: rtl/uivg_chk.sv
// Checker: temporal properties of the vector generator, bound into the top.
module uivg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       strap_restart,
    input logic [2:0] port_addr_hi,
    input logic       chan_b,
    input logic       inta,
    input logic       irq,
    input logic       rx_avail,
    input logic       sense_in,
    input logic       sense_q,
    input logic       en_q,
    input logic [7:0] poll_vec,
    input logic [7:0] pend_q,
    input logic [7:0] set_v,
    input logic [4:0] tmr_exp,
    input logic [2:0] win_code
);
    logic [2:0] last_code;

    // Remembers the winner code from the previous cycle for the clear check.
    always_ff @(posedge clk) begin
        if (!rst_n) last_code <= '0;
        else        last_code <= win_code;
    end

    // R2
    vect_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strap_restart && irq) |-> (poll_vec[7:5] == port_addr_hi &&
                                     poll_vec[4] == chan_b && !poll_vec[0]));
    // R3
    restart_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_restart && irq) |-> (poll_vec[7:6] == 2'b11 && poll_vec[2:0] == 3'b111));
    // R6
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> en_q);
    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && irq && set_v == 8'h00) |=> !pend_q[last_code]);
    // R8
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail |=> pend_q[4]);
    // R9
    sense_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_in && !sense_q) |=> pend_q[2]);
    // R10
    tmr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_exp[0] |=> pend_q[0]);
endmodule

bind uart_irq_vector_gen uivg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .strap_restart(strap_restart),
    .port_addr_hi(port_addr_hi), .chan_b(chan_b), .inta(inta), .irq(irq),
    .rx_avail(rx_avail), .sense_in(sense_in), .sense_q(sense_q), .en_q(en_q),
    .poll_vec(poll_vec), .pend_q(pend_q), .set_v(set_v), .tmr_exp(tmr_exp),
    .win_code(win_code)
);

// File: tb/uart_irq_vector_gen_bench.sv
// Scoreboard bench: the acknowledge driver queues the expected vectors, and a
// monitor pops and compares them during each acknowledge cycle.
module uart_irq_vector_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;

    logic clk = 0, rst_n = 0;
    logic strap_restart = 0, chan_b = 0;
    logic [2:0] port_addr_hi = 3'b001;
    logic mask_wr = 0, ctrl_wr = 0, ctrl_gen_en = 0, tmr_load = 0;
    logic [7:0] mask_data = 0, tmr_value = 0;
    logic [2:0] tmr_sel = 0;
    logic sense_in = 0, rx_avail = 0, rx_read = 0, tx_empty = 0, tx_write = 0, inta = 0;
    logic irq;
    logic [7:0] ack_vec, poll_vec;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    uart_irq_vector_gen #(.TICK_DIV(DIV)) u_uart_irq_vector_gen (
        .clk(clk), .rst_n(rst_n), .strap_restart(strap_restart),
        .port_addr_hi(port_addr_hi), .chan_b(chan_b), .mask_wr(mask_wr),
        .mask_data(mask_data), .ctrl_wr(ctrl_wr), .ctrl_gen_en(ctrl_gen_en),
        .tmr_load(tmr_load), .tmr_sel(tmr_sel), .tmr_value(tmr_value),
        .sense_in(sense_in), .rx_avail(rx_avail), .rx_read(rx_read),
        .tx_empty(tx_empty), .tx_write(tx_write), .inta(inta), .irq(irq),
        .ack_vec(ack_vec), .poll_vec(poll_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected vector from the requirement formulas (R2, R3).
    function automatic logic [7:0] ev(input logic rst_mode, input logic [2:0] code);
        if (rst_mode) return {2'b11, code, 3'b111};
        return {port_addr_hi, chan_b, code, 1'b0};
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, expv);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Ends a one-cycle drive and lets the registers settle to the next negedge.
    task automatic fin;
        @(posedge clk); #1;
        mask_wr = 0; ctrl_wr = 0; tmr_load = 0; rx_avail = 0; rx_read = 0;
        tx_empty = 0; tx_write = 0; inta = 0;
        @(negedge clk);
    endtask

    task automatic wr_mask(input logic [7:0] m);
        @(posedge clk); #1; mask_wr = 1; mask_data = m; fin();
    endtask

    task automatic load_tmr(input logic [2:0] s, input logic [7:0] v);
        @(posedge clk); #1; tmr_load = 1; tmr_sel = s; tmr_value = v; fin();
    endtask

    // Driver: queues the expected vector, then runs one acknowledge cycle.
    task automatic ack(input logic [7:0] expv, input string tag);
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(posedge clk); #1; inta = 1; fin();
    endtask

    // Monitor: compares the acknowledge bus against the scoreboard head.
    always @(negedge clk) begin
        if (inta) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R7 unexpected ack actual=%02h expected=none", ack_vec);
            end else begin
                chk(ack_vec, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        int n;
        cyc(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk({7'd0, irq}, 8'h00, "R1 irq");
        chk(poll_vec, 8'hFF, "R1 poll");
        chk(ack_vec, 8'hFF, "R1 ack idle");

        // R5: a masked receive flag is latched but hidden
        @(posedge clk); #1; rx_avail = 1; fin();
        chk(poll_vec, 8'hFF, "R5 masked hidden");
        wr_mask(8'h70);
        chk(poll_vec, ev(0, 3'd4), "R5 R2 unmask shows rx 28");
        // R6: no irq until generation is enabled
        chk({7'd0, irq}, 8'h00, "R6 gen off");
        @(posedge clk); #1; ctrl_wr = 1; ctrl_gen_en = 1; fin();
        chk({7'd0, irq}, 8'h01, "R6 gen on");
        // R7: acknowledge returns the vector and clears the flag
        ack(8'h28, "R7 ack rx");
        chk(poll_vec, 8'hFF, "R7 cleared");
        chk(ack_vec, 8'hFF, "R7 idle bus");

        // R8: transmit set and clear by write
        @(posedge clk); #1; tx_empty = 1; fin();
        chk(poll_vec, 8'h2A, "R8 tx set");
        @(posedge clk); #1; tx_write = 1; fin();
        chk(poll_vec, 8'hFF, "R8 tx write clears");
        // R8: receive cleared by data read
        @(posedge clk); #1; rx_avail = 1; fin();
        @(posedge clk); #1; rx_read = 1; fin();
        chk(poll_vec, 8'hFF, "R8 rx read clears");

        // R4 priority: receive beats transmit
        @(posedge clk); #1; rx_avail = 1; tx_empty = 1; fin();
        ack(8'h28, "R4 first rx");
        ack(8'h2A, "R4 then tx");

        // R11: set wins over clear in the same cycle
        @(posedge clk); #1; rx_avail = 1; rx_read = 1; fin();
        chk(poll_vec, 8'h28, "R11 set wins");
        ack(8'h28, "R11 drain");

        // R2 channel B
        chan_b = 1;
        @(posedge clk); #1; rx_avail = 1; fin();
        chk(poll_vec, ev(0, 3'd4), "R2 chan b 38");
        ack(8'h38, "R2 ack chan b");
        chan_b = 0;

        // R3 restart format, R9 sense edge
        strap_restart = 1;
        wr_mask(8'hFF);
        @(posedge clk); #1; rx_avail = 1; sense_in = 1; fin();
        ack(8'hD7, "R9 R4 sense first");
        ack(8'hE7, "R3 rx restart");
        cyc(3); @(negedge clk);
        chk({7'd0, irq}, 8'h00, "R9 held level no retrigger");
        sense_in = 0;

        // R10 timer1 expiry window
        load_tmr(3'd0, 8'd3);
        n = 0;
        while (!irq && n < 3*DIV + 6) begin @(negedge clk); n++; end
        chk({7'd0, (n >= 2*DIV && n <= 3*DIV + 2)}, 8'h01, "R10 expiry window");
        chk(poll_vec, 8'hC7, "R10 R3 timer1 C7");
        // R10 reload with 0 clears the fired flag
        load_tmr(3'd0, 8'd0);
        chk({7'd0, irq}, 8'h00, "R10 reload clears");
        // R10 load 0 stops a running timer
        load_tmr(3'd3, 8'd3);
        load_tmr(3'd3, 8'd0);
        cyc(4*DIV); @(negedge clk);
        chk({7'd0, irq}, 8'h00, "R10 zero stops");
        // R10 timer5: restart vector FF, told apart by irq
        load_tmr(3'd4, 8'd1);
        cyc(DIV + 3); @(negedge clk);
        chk({7'd0, irq}, 8'h01, "R10 timer5 irq");
        ack(8'hFF, "R3 timer5 FF");
        chk({7'd0, irq}, 8'h00, "R7 timer5 cleared");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule